// File: doc/BRIEF.md
# Slewing Logarithmic Stereo Attenuator

This block sets the level of a stereo stream of signed 24-bit samples, one left and one right sample per audio frame. An 8-bit attenuation code picks a gain on a logarithmic scale. Code 0 is unity. Each code step adds 0.375 dB of attenuation, so the largest code gives 95.625 dB. The frame strobe `in_valid` marks each sample pair. Both channels share one gain.

The applied gain never jumps. A register holds the applied gain index, and it moves one code (0.375 dB) toward the programmed code on each frame until the two are equal. A new code written during a ramp redirects the ramp from wherever the index stands. The mute input makes the index ramp to the deepest entry and then forces exact zeros out, so muting is click-free. Releasing mute ramps the index back to the programmed code. The data path keeps running while muted.

Top module: `slew_attenuator`

## Requirements
- R1: During reset and after it, `out_valid` is 0 and both outputs are 0. Reset also returns the applied gain index to 0 (unity), so the first frame after reset passes its samples unchanged whatever the code.
- R2: The gain for index k is G(k) = round(2^23 · 10^(−0.375·k/20)), an unsigned multiplier with 23 fraction bits. G(0) = 2^23 is exactly unity.
- R3: Each output is floor((x·G + 2^22) / 2^23), where x is that channel's signed input and G is the gain that applies to the frame. The result is saturated to the signed 24-bit range. Left and right use the same G in the same frame.
- R4: `out_valid` is high for exactly one cycle, two clock cycles after the cycle in which `in_valid` was sampled high, and it is low otherwise. Each output frame corresponds to exactly one input frame.
- R5: A frame is processed with the index the block holds when that frame arrives. The index then moves one step toward the goal, which is the attenuation code, or 255 while mute is high. After a change of goal, the number of frames before the goal gain first appears at the output equals the absolute difference between the old index and the new goal.
- R6: Without `in_valid`, the index does not move, however long the code has differed from it.
- R7: A change of code while a ramp is running takes effect from the current index, with no jump back to the old target.
- R8: While mute is high, the index ramps to 255. A frame that arrives with mute high and the index at 255 produces exact zeros on both channels. Before the index reaches 255, frames are scaled normally.
- R9: When mute drops, the first frame still uses index 255. The index then ramps back to the code one step per frame.
- R10: Left and right data are processed independently. Each output depends only on its own input sample and the shared gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | One-cycle strobe per audio frame |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| atten_code | input | 8 | Requested attenuation, 0.375 dB per code |
| mute | input | 1 | Ramp down to the deepest step, then output zero |
| out_valid | output | 1 | Output frame strobe |
| out_left | output | 24 | Scaled left sample |
| out_right | output | 24 | Scaled right sample |

## Verification
A wrong applied index is visible on the very next output frame. With a full-scale input, each index gives a distinct output value, so a skipped step, a double step or a jump shows up as a wrong sample in the same frame. Frame counting is made exact by timing how many full-scale frames pass before the goal gain appears. That count exposes slew that runs too fast, stalls, restarts on a retarget, or moves without a strobe. A mute that zeros too early or too late is caught on the single frame where the index first reaches 255.

// File: rtl/atten_pkg.sv
package atten_pkg;

  // Linear multiplier for attenuation index k: frac fraction bits,
  // step_db decibels of attenuation per index.
  function automatic int gain_entry(int k, int frac, real step_db);
    real lin;
    lin = (2.0 ** real'(frac)) * (10.0 ** (-(step_db * real'(k)) / 20.0));
    return $rtoi(lin + 0.5);
  endfunction

endpackage

// File: rtl/atten_slew_ctrl.sv
module atten_slew_ctrl #(
  parameter int IDX_W     = 8,
  parameter int RESET_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_en,
  input  logic [IDX_W-1:0] target_code,
  input  logic             mute,
  output logic [IDX_W-1:0] cur_idx
);
  localparam logic [IDX_W-1:0] MAX_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] goal;

  always_comb goal = mute ? MAX_IDX : target_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= IDX_W'(RESET_IDX);
    end else if (step_en) begin
      if (cur_idx < goal)      cur_idx <= cur_idx + 1'b1;
      else if (cur_idx > goal) cur_idx <= cur_idx - 1'b1;
    end
  end

  // R6: index frozen between frames
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !step_en |=> $stable(cur_idx));

  // R5: one step toward the goal per frame
  p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && cur_idx < goal) |=> cur_idx == $past(cur_idx) + 1'b1);
  p_step_down_r5: assert property (@(posedge clk) disable iff (rst)
    (step_en && cur_idx > goal) |=> cur_idx == $past(cur_idx) - 1'b1);

  // R8: mute drives index toward the deepest entry only
  p_mute_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (step_en && mute) |=> cur_idx >= $past(cur_idx));

endmodule

// File: rtl/atten_gain_rom.sv
module atten_gain_rom #(
  parameter int  IDX_W   = 8,
  parameter int  GAIN_W  = 24,
  parameter int  FRAC    = 23,
  parameter real STEP_DB = 0.375
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  output logic [GAIN_W-1:0] gain
);
  localparam int DEPTH = 1 << IDX_W;

  logic [GAIN_W-1:0] table_mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++)
      table_mem[k] = GAIN_W'(atten_pkg::gain_entry(k, FRAC, STEP_DB));
  end

  always_ff @(posedge clk) begin
    if (rd_en) gain <= table_mem[addr];
  end

endmodule

// File: rtl/atten_scale.sv
module atten_scale #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 24,
  parameter int FRAC   = 23
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     zero,
  input  logic signed [DATA_W-1:0] x,
  input  logic        [GAIN_W-1:0] g,
  output logic signed [DATA_W-1:0] y
);
  localparam int PROD_W = DATA_W + GAIN_W + 1;
  localparam logic signed [PROD_W-1:0] RND  = PROD_W'(1) << (FRAC - 1);
  localparam logic signed [PROD_W-1:0] MAXV = (PROD_W'(1) << (DATA_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] MINV = -(PROD_W'(1) << (DATA_W - 1));

  logic signed [PROD_W-1:0] x_ext, g_ext, prod, shf;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    x_ext = PROD_W'(x);
    g_ext = $signed({{(PROD_W-GAIN_W){1'b0}}, g});
    prod  = x_ext * g_ext;
    shf   = (prod + RND) >>> FRAC;
    if (shf > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (shf < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     y <= '0;
    else if (en) y <= zero ? '0 : sat;
  end

  // R8: forced silence reaches the output on the next edge
  p_zero_out_r8: assert property (@(posedge clk) disable iff (rst)
    (en && zero) |=> y == '0);

  // R4: output held between frames
  p_hold_y_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(y));

endmodule

// File: rtl/slew_attenuator.sv
module slew_attenuator #(
  parameter int  DATA_W    = 24,
  parameter int  IDX_W     = 8,
  parameter int  GAIN_W    = 24,
  parameter int  FRAC      = 23,
  parameter real STEP_DB   = 0.375,
  parameter int  RESET_IDX = 0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  input  logic        [IDX_W-1:0]  atten_code,
  input  logic                     mute,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  localparam int NCH = 2;
  localparam logic [IDX_W-1:0] MAX_IDX = {IDX_W{1'b1}};

  logic [IDX_W-1:0]         cur_idx;
  logic [GAIN_W-1:0]        gain_q;
  logic                     v1, z1;
  logic signed [DATA_W-1:0] smp_in [NCH];
  logic signed [DATA_W-1:0] smp_q  [NCH];
  logic signed [DATA_W-1:0] smp_out[NCH];

  assign smp_in[0] = in_left;
  assign smp_in[1] = in_right;

  atten_slew_ctrl #(.IDX_W(IDX_W), .RESET_IDX(RESET_IDX)) u_ctrl (
    .clk(clk), .rst(rst), .step_en(in_valid),
    .target_code(atten_code), .mute(mute), .cur_idx(cur_idx)
  );

  atten_gain_rom #(.IDX_W(IDX_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .STEP_DB(STEP_DB)) u_rom (
    .clk(clk), .rd_en(in_valid), .addr(cur_idx), .gain(gain_q)
  );

  // Stage 1: capture samples and mute decision alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      z1 <= 1'b0;
    end else begin
      v1 <= in_valid;
      if (in_valid) z1 <= mute && (cur_idx == MAX_IDX);
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int c = 0; c < NCH; c++) smp_q[c] <= smp_in[c];
    end
  end

  // Stage 2: per-channel multiply, round, saturate
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    atten_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_scale (
      .clk(clk), .rst(rst), .en(v1), .zero(z1),
      .x(smp_q[c]), .g(gain_q), .y(smp_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
  end

  assign out_left  = smp_out[0];
  assign out_right = smp_out[1];

  // R4: fixed two-cycle latency, no spurious strobes
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));

  // R2: unity at index 0 passes the sample through
  p_unity_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !mute && cur_idx == '0) |-> ##2
      (out_left == $past(in_left, 2) && out_right == $past(in_right, 2)));

  // R8: muted at the deepest index gives silence on both channels
  p_mute_silence_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mute && cur_idx == MAX_IDX) |-> ##2
      (out_left == '0 && out_right == '0));

endmodule

// File: tb/tb_slew_attenuator.sv
module tb_slew_attenuator;
  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic signed [23:0] in_left, in_right;
  logic [7:0] atten_code;
  logic mute;
  logic out_valid;
  logic signed [23:0] out_left, out_right;

  always #2.5 clk = ~clk;

  slew_attenuator dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left), .in_right(in_right),
    .atten_code(atten_code), .mute(mute), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right)
  );

  int tests = 0;
  int fails = 0;
  int m_idx = 0;
  bit done = 1'b0;

  localparam int NV = 8;
  localparam int V_CODE[NV] = '{0, 16, 5, 200, 255, 0, 1, 40};
  localparam int V_R[NV]    = '{-8388608, 1234567, -1, 8388607, -4000000, 0, 777, -2};
  localparam int V_N[NV]    = '{0, 16, 11, 195, 55, 255, 1, 39};

  function automatic int gain_of(int k);
    return $rtoi((2.0 ** 23) * (10.0 ** (-(0.375 * real'(k)) / 20.0)) + 0.5);
  endfunction

  function automatic logic signed [23:0] model(logic signed [23:0] x, int idx, bit z);
    longint p;
    if (z) return '0;
    p = longint'(x) * longint'(gain_of(idx)) + 64'sd4194304;
    p = p >>> 23;
    if (p > 64'sd8388607) p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return p[23:0];
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge; checks timing and both outputs.
  task automatic frame(logic signed [23:0] l, logic signed [23:0] r, string req);
    logic signed [23:0] el, er;
    bit z;
    int goal;
    z  = mute && (m_idx == 255);
    el = model(l, m_idx, z);
    er = model(r, m_idx, z);
    goal = mute ? 255 : int'(atten_code);
    if (m_idx < goal) m_idx++;
    else if (m_idx > goal) m_idx--;
    in_valid = 1'b1; in_left = l; in_right = r;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R4", "out_valid low one cycle after strobe", longint'(out_valid), 0);
    @(posedge clk); @(negedge clk);
    chk("R4", "out_valid high two cycles after strobe", longint'(out_valid), 1);
    chk(req, "left", longint'(out_left), longint'(el));
    chk("R10", "right", longint'(out_right), longint'(er));
  endtask

  // Counts frames until the goal gain appears on a full-scale left input.
  task automatic count_to_goal(int exp_n, string req);
    logic signed [23:0] target_out;
    int n = 0;
    bit hit = 1'b0;
    int goal;
    goal = mute ? 255 : int'(atten_code);
    target_out = model(24'sh7FFFFF, goal, mute);
    while (!hit && n < 300) begin
      frame(24'sh7FFFFF, -24'sd3, req);
      if (out_left == target_out) hit = 1'b1;
      else n++;
    end
    chk(req, "frames to reach goal", n, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_left = '0; in_right = '0; atten_code = '0; mute = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", longint'(out_valid), 0);
    chk("R1", "out_left in reset", longint'(out_left), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "out_right after reset", longint'(out_right), 0);

    // Vector table: code, right sample, expected frames to settle
    for (int i = 0; i < NV; i++) begin
      atten_code = 8'(V_CODE[i]);
      count_to_goal(V_N[i], "R5");
      frame(24'sh7FFFFF, 24'(V_R[i]), "R2");
      frame(-24'sd1000, 24'(V_R[i]), "R3");
    end

    // R6: no movement without strobes
    atten_code = 8'd100;
    repeat (50) @(negedge clk);
    frame(24'sh7FFFFF, 24'sd5, "R6");
    chk("R6", "index held at old code before strobe", longint'(out_left),
        longint'(model(24'sh7FFFFF, 40, 1'b0)));

    // R7: retarget mid-ramp (index now 41, run to 50, then aim at 45)
    repeat (9) frame(24'sh400000, -24'sh400000, "R7");
    atten_code = 8'd45;
    count_to_goal(5, "R7");

    // R8: mute ramps to 255 then silences
    mute = 1'b1;
    count_to_goal(210, "R8");
    frame(24'sh7FFFFF, -24'sh7FFFFF, "R8");
    chk("R8", "muted right silent", longint'(out_right), 0);

    // R9: release ramps back, first frame still deepest index
    mute = 1'b0;
    frame(24'sh7FFFFF, 24'sd0, "R9");
    chk("R9", "first unmuted frame at index 255", longint'(out_left), longint'(gain_of(255)));
    count_to_goal(209, "R9");

    // R3: negative rounding and extremes at a mid code
    atten_code = 8'd48;
    count_to_goal(3, "R5");
    frame(-24'sh800000, 24'sd1, "R3");
    frame(24'sd3, -24'sd3, "R3");

    // R1: reset mid-ramp returns to unity
    atten_code = 8'd200;
    repeat (5) frame(24'sd100, 24'sd100, "R5");
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1", "out_valid during mid reset", longint'(out_valid), 0);
    rst = 1'b0; m_idx = 0;
    @(negedge clk);
    frame(24'sh123456, -24'sh123456, "R1");
    chk("R1", "unity after reset", longint'(out_left), longint'(24'sh123456));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule